// File: doc/BRIEF.md
# Tuning Window Center Selector

This block picks a sampling tap after a tuning sweep. The sweep probes each of `NUM_TAPS` taps twice and delivers the results as one pass/fail bitmap of `2*NUM_TAPS` bits. Bit `i` and bit `i+NUM_TAPS` are the two probes of tap `i`, and a set bit means that probe passed. A single-cycle start pulse captures the bitmap. In the same cycle the block keeps only taps that passed in both probes. It then scans the doubled bitmap one bit per clock, looking for the longest unbroken stretch of passing bits.

When the scan ends, the block reports through a one-cycle done pulse. The pulse carries either a valid flag or an error flag. On success the centre of the widest stretch is folded back into the tap range and driven on the tap-set output, and the auto-retune enable is raised. Both outputs hold until a later selection succeeds. Issuing the tuning commands and gathering the bitmap happen outside this block.

Top module: `tuning_tap_selector`

## Requirements
- R1: After reset `busy_o`, `done_o`, `valid_o`, `error_o` and `retune_en_o` are 0, and `tap_set_o` is 0.
- R2: The bitmap is sampled only on the clock edge at which `start_i` is seen while `busy_o` is 0, and `busy_o` is 1 from the next cycle. A `start_i` pulse or a bitmap change while busy does not alter the result or the timing of the scan in progress.
- R3: Tap `t` counts as passing only if both bit `t` and bit `t+NUM_TAPS` of `probe_map_i` are 1. A failing tap clears both of its positions in the scanned bitmap.
- R4: The block selects the longest run of consecutive set bits across all `2*NUM_TAPS` merged positions (index 0 upward). A later run replaces the best run only if it is strictly longer, so among equal runs the lowest-indexed one wins.
- R5: A run that is still open at the last bit position is compared against the best run like any other run.
- R6: Selection succeeds only if the best run is at least 3 bits long. Otherwise the result is an error.
- R7: The chosen tap is `((first + last) / 2) mod NUM_TAPS`, with integer division, where first and last are the indices of the best run. It is always below `NUM_TAPS`.
- R8: On success `tap_set_o` takes the chosen tap and `retune_en_o` becomes 1. Both keep those values until the next success or reset.
- R9: On an error result, `tap_set_o` and `retune_en_o` keep their previous values.
- R10: If start is sampled at edge k, `done_o` is 1 for exactly the one cycle after edge k+2*NUM_TAPS+1. In that cycle exactly one of `valid_o` and `error_o` is 1. Both are 0 whenever `done_o` is 0, and `busy_o` is 0 while `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| probe_map_i | input | 2*NUM_TAPS | Pass bitmap of both probe runs, tap t at bits t and t+NUM_TAPS |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result pulse |
| valid_o | output | 1 | Result is a selected tap (with done_o) |
| error_o | output | 1 | No window of at least 3 bits (with done_o) |
| tap_set_o | output | $clog2(NUM_TAPS) | Selected sampling tap, held |
| retune_en_o | output | 1 | Auto-retune enable, set on first success |

## Verification
A run that ends at the last bit is closed out in the same cycle that makes the pass/fail decision and computes the folded centre. That close-out therefore meets the strictly-longer rule and the minimum-length check at the same time. An all-pass bitmap, whose only run is still open at the end, provokes this case: the block must report tap 7 with valid rather than an error. A bitmap of equal-length runs checks that this last comparison does not let a tie displace an earlier run. The second coincidence is a start pulse arriving mid-scan with a different bitmap. The bench judges it by the unchanged result of the first bitmap and by the done pulse appearing exactly 2*NUM_TAPS+2 edges after the first start.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FINAL = 2'd2
    } tapsel_state_e;

    // Shortest passing window that still yields a selection
    localparam int unsigned TAPSEL_MIN_RUN = 3;

    // Midpoint of a window, folded back into the tap range.
    // The midpoint is always below 2*taps, so one subtraction suffices.
    function automatic int unsigned tapsel_fold(input int unsigned first,
                                                input int unsigned last,
                                                input int unsigned taps);
        int unsigned mid;
        mid = (first + last) / 2;
        if (mid >= taps) begin
            mid = mid - taps;
        end
        return mid;
    endfunction

endpackage

// File: rtl/tapsel_merge.sv
module tapsel_merge #(
    parameter int unsigned NUM_TAPS = 8,
    localparam int unsigned MAP_W   = 2 * NUM_TAPS
) (
    input  logic [MAP_W-1:0] raw_i,
    output logic [MAP_W-1:0] merged_o
);
    // A tap passes only if both of its probes passed
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        logic both_ok;
        assign both_ok                 = raw_i[t] & raw_i[t + NUM_TAPS];
        assign merged_o[t]             = both_ok;
        assign merged_o[t + NUM_TAPS]  = both_ok;
    end
endmodule

// File: rtl/tapsel_run_scan.sv
module tapsel_run_scan #(
    parameter int unsigned MAP_W = 16,
    localparam int unsigned IDX_W = $clog2(MAP_W),
    localparam int unsigned LEN_W = $clog2(MAP_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             bit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [LEN_W-1:0] fin_len_o,
    output logic [IDX_W-1:0] fin_first_o,
    output logic [IDX_W-1:0] fin_last_o
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
    } window_t;

    logic [LEN_W-1:0] run_q;
    window_t          best_q;
    window_t          open_w;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            run_q  <= '0;
            best_q <= '0;
        end else if (step_i) begin
            if (bit_i) begin
                run_q <= run_q + LEN_W'(1);
            end else begin
                if (run_q > best_q.len) begin
                    best_q.len   <= run_q;
                    best_q.first <= idx_i - IDX_W'(run_q);
                    best_q.last  <= idx_i - IDX_W'(1);
                end
                run_q <= '0;
            end
        end
    end

    // Window still open after the last position
    always_comb begin
        open_w.len   = run_q;
        open_w.first = IDX_W'(LEN_W'(MAP_W) - run_q);
        open_w.last  = IDX_W'(MAP_W - 1);
    end

    // Final comparison, strictly longer wins
    always_comb begin
        if (open_w.len > best_q.len) begin
            fin_len_o   = open_w.len;
            fin_first_o = open_w.first;
            fin_last_o  = open_w.last;
        end else begin
            fin_len_o   = best_q.len;
            fin_first_o = best_q.first;
            fin_last_o  = best_q.last;
        end
    end
endmodule

// File: rtl/tapsel_pick.sv
module tapsel_pick
    import tapsel_pkg::*;
#(
    parameter int unsigned NUM_TAPS = 8,
    localparam int unsigned MAP_W   = 2 * NUM_TAPS,
    localparam int unsigned IDX_W   = $clog2(MAP_W),
    localparam int unsigned LEN_W   = $clog2(MAP_W + 1),
    localparam int unsigned TAP_W   = $clog2(NUM_TAPS)
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic [IDX_W-1:0] first_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             ok_o,
    output logic [TAP_W-1:0] tap_o
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(TAPSEL_MIN_RUN);

    always_comb begin
        ok_o  = (len_i >= MIN_LEN);
        tap_o = TAP_W'(tapsel_fold(32'(first_i), 32'(last_i), NUM_TAPS));
    end
endmodule

// File: rtl/tuning_tap_selector.sv
module tuning_tap_selector
    import tapsel_pkg::*;
#(
    parameter int unsigned NUM_TAPS = 8,
    localparam int unsigned MAP_W   = 2 * NUM_TAPS,
    localparam int unsigned IDX_W   = $clog2(MAP_W),
    localparam int unsigned LEN_W   = $clog2(MAP_W + 1),
    localparam int unsigned TAP_W   = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [MAP_W-1:0] probe_map_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             valid_o,
    output logic             error_o,
    output logic [TAP_W-1:0] tap_set_o,
    output logic             retune_en_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAP_W - 1);

    tapsel_state_e    state_q;
    logic [MAP_W-1:0] map_q;
    logic [MAP_W-1:0] merged_w;
    logic [IDX_W-1:0] idx_q;
    logic             accept_w;
    logic [LEN_W-1:0] fin_len_w;
    logic [IDX_W-1:0] fin_first_w;
    logic [IDX_W-1:0] fin_last_w;
    logic             pick_ok_w;
    logic [TAP_W-1:0] pick_tap_w;

    assign accept_w = (state_q == ST_IDLE) && start_i;

    tapsel_merge #(.NUM_TAPS(NUM_TAPS)) u_merge (
        .raw_i    (probe_map_i),
        .merged_o (merged_w)
    );

    tapsel_run_scan #(.MAP_W(MAP_W)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (accept_w),
        .step_i      (state_q == ST_SCAN),
        .bit_i       (map_q[idx_q]),
        .idx_i       (idx_q),
        .fin_len_o   (fin_len_w),
        .fin_first_o (fin_first_w),
        .fin_last_o  (fin_last_w)
    );

    tapsel_pick #(.NUM_TAPS(NUM_TAPS)) u_pick (
        .len_i   (fin_len_w),
        .first_i (fin_first_w),
        .last_i  (fin_last_w),
        .ok_o    (pick_ok_w),
        .tap_o   (pick_tap_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            map_q       <= '0;
            idx_q       <= '0;
            done_o      <= 1'b0;
            valid_o     <= 1'b0;
            error_o     <= 1'b0;
            tap_set_o   <= '0;
            retune_en_o <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            valid_o <= 1'b0;
            error_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        map_q   <= merged_w;
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    done_o  <= 1'b1;
                    valid_o <= pick_ok_w;
                    error_o <= !pick_ok_w;
                    if (pick_ok_w) begin
                        tap_set_o   <= pick_tap_w;
                        retune_en_o <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/tapsel_checker.sv
module tapsel_checker #(
    parameter int unsigned NUM_TAPS = 8,
    localparam int unsigned TAP_W   = $clog2(NUM_TAPS)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             valid_o,
    input logic             error_o,
    input logic [TAP_W-1:0] tap_set_o,
    input logic             retune_en_o
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_tap_range_r7: assert property (@(posedge clk) disable iff (rst)
        32'(tap_set_o) < NUM_TAPS);

    p_retune_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        retune_en_o |=> retune_en_o);

    p_retune_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(retune_en_o) |-> (done_o && valid_o));

    p_tap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(done_o && valid_o) |-> $stable(tap_set_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (valid_o ^ error_o));

    p_flags_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (!valid_o && !error_o));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

bind tuning_tap_selector tapsel_checker #(.NUM_TAPS(NUM_TAPS)) u_tapsel_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .valid_o     (valid_o),
    .error_o     (error_o),
    .tap_set_o   (tap_set_o),
    .retune_en_o (retune_en_o)
);

// File: tb/tuning_tap_selector_tb_top.sv
module tuning_tap_selector_tb_top;
    localparam int NT  = 8;
    localparam int MW  = 2 * NT;
    localparam int LAT = MW + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [MW-1:0] probe_map_i = '0;
    logic          busy_o, done_o, valid_o, error_o, retune_en_o;
    logic [2:0]    tap_set_o;

    int n_checks = 0;
    int n_fail   = 0;
    int hold_tap = 0;
    int hold_rt  = 0;

    always #4 clk = ~clk;

    tuning_tap_selector #(.NUM_TAPS(NT)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .probe_map_i(probe_map_i),
        .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .error_o(error_o),
        .tap_set_o(tap_set_o), .retune_en_o(retune_en_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Runs one selection; optionally injects a second start mid-scan (R2)
    task automatic run_case(input logic [MW-1:0] map, input bit exp_ok,
                            input int exp_tap, input string req,
                            input bit inject);
        int cnt = 0;
        bit got = 0;
        @(negedge clk);
        probe_map_i = map;
        start_i     = 1'b1;
        while (!got && cnt < 4 * LAT) begin
            @(posedge clk);
            #1;
            cnt++;
            start_i = 1'b0;
            if (cnt == 1) check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
            if (inject && cnt == 4) begin
                start_i     = 1'b1;
                probe_map_i = ~map;
            end
            if (done_o) got = 1;
        end
        check(cnt == LAT, "R10", {req, " done latency"}, cnt, LAT);
        check(valid_o == exp_ok, req, "valid flag", int'(valid_o), int'(exp_ok));
        check(error_o == !exp_ok, req, "error flag", int'(error_o), int'(!exp_ok));
        if (exp_ok) begin
            hold_tap = exp_tap;
            hold_rt  = 1;
        end
        check(int'(tap_set_o) == hold_tap, exp_ok ? "R7" : "R9", {req, " tap_set"},
              int'(tap_set_o), hold_tap);
        check(int'(retune_en_o) == hold_rt, exp_ok ? "R8" : "R9", {req, " retune"},
              int'(retune_en_o), hold_rt);
        check(busy_o == 1'b0, "R10", "busy low at done", int'(busy_o), 0);
        @(posedge clk);
        #1;
        check(done_o == 1'b0 && valid_o == 1'b0 && error_o == 1'b0, "R10",
              "pulse length", int'(done_o), 0);
        if (inject) begin
            for (int k = 0; k < LAT + 2; k++) begin
                @(posedge clk);
                #1;
                check(done_o == 1'b0, "R2", "no second result", int'(done_o), 0);
            end
        end
        check(int'(tap_set_o) == hold_tap, "R8", "tap held after done", int'(tap_set_o), hold_tap);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check(busy_o == 0 && done_o == 0 && valid_o == 0 && error_o == 0, "R1",
              "idle flags", int'({busy_o, done_o, valid_o, error_o}), 0);
        check(tap_set_o == 0 && retune_en_o == 0, "R1", "tap/retune",
              int'({tap_set_o, retune_en_o}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        // R2: first bitmap empty, mid-scan start with full bitmap is ignored
        run_case(16'h0000, 1'b0, 0, "R2", 1'b1);
        // R5: single run open at the last bit
        run_case(16'hFFFF, 1'b1, 7, "R5", 1'b0);
        // R6: longest run only 2 bits
        run_case(16'h1818, 1'b0, 0, "R6", 1'b0);
        // R9: nothing passes, outputs held
        run_case(16'h0000, 1'b0, 0, "R9", 1'b0);
        // R3: second probe run all failed
        run_case(16'h00FF, 1'b0, 0, "R3", 1'b0);
        // R4: equal runs, lowest one kept (tap 1, not 5)
        run_case(16'h7777, 1'b1, 1, "R4", 1'b0);
        // R3: merge trims window to taps 0..3 (tap 1, not 5)
        run_case(16'h0FFF, 1'b1, 1, "R3", 1'b0);
        // R7: best run 7..12, centre 9 folds to 1
        run_case(16'h9F9F, 1'b1, 1, "R7", 1'b0);
        // R4: run spanning the half boundary 6..9
        run_case(16'hC3C3, 1'b1, 7, "R4", 1'b0);
        // R6: exactly 3 bits suffice
        run_case(16'h1E3C, 1'b1, 3, "R6", 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule